// File: doc/BRIEF.md
# Synchronous Transmit Handshake Sequencer

This block times the modem handshake of a synchronous serial transmitter. It is clocked by the transmit clock and updates every output on the falling edge. When the transmit queue in front of it holds frame data, it raises the request-to-send line (`rts`). Serial output starts only once the clear-to-send input permits it. The block then shifts out one whole frame: an opening flag, the payload bytes taken one by one from the queue, and a closing flag. It drops `rts` one bit period after the last flag bit.

The queue is read through a byte-wide, show-ahead port. `fifo_data` and `fifo_eof` describe the head entry whenever `fifo_empty` is low. A one-period `fifo_rd` pulse tells the queue to discard that entry. A configuration input can declare the clear-to-send pin unused, and the input is then treated as always asserted. Software is expected to drop `tx_en` and raise it again after any change to that configuration. While `tx_en` is low the sequencer is held idle and any frame in progress is abandoned.

Top module: `tx_handshake_seq`

## Requirements
- R1: While reset is active, `rts` is 0, `txd` is 1 and `fifo_rd` is 0.
- R2: `rts` rises only on a falling edge of `tclk` at which `tx_en` is 1 and `fifo_empty` is 0. With the queue empty, or with `tx_en` low, `rts` stays 0.
- R3: If clear-to-send is granted (`cts` or `cts_forced` is 1) on the edge where `rts` rises, the first opening-flag bit is driven on `txd` on that same edge. The delay from `rts` to data is zero bit periods.
- R4: If clear-to-send is refused when `rts` rises, `rts` stays 1 and `txd` stays 1. The first flag bit follows on the first falling edge at which `cts` is sampled high.
- R5: With `cts_forced` = 1 the level on `cts` has no effect, and frames start as in R3.
- R6: A frame on `txd` is laid out as follows. It begins with the FLAG_PAT pattern (default 0x7E), sent LSB first. The payload bytes follow in queue order, each LSB first, up to and including the byte whose `fifo_eof` is 1. The frame ends with FLAG_PAT again, LSB first. Each bit lasts one `tclk` period.
- R7: After the last closing-flag bit, `rts` stays 1 with `txd` = 1 for exactly one more period, and then falls.
- R8: When the next frame is already queued at the end of a frame, `rts` stays low for exactly one period and then rises with its first flag bit.
- R9: One falling edge after `tx_en` is sampled low, `rts` is 0 and `txd` is 1, and any frame in progress is abandoned. The next frame starts again with an opening flag.
- R10: `fifo_rd` pulses high for one period per payload byte, in the period after that byte's first bit is driven. `fifo_rd` is high only while `rts` is 1.
- R11: `txd` is 1 whenever `rts` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tclk | input | 1 | Transmit clock; outputs change on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_en | input | 1 | Transmitter enable; low forces idle and aborts a frame |
| cts | input | 1 | Clear-to-send, active high |
| cts_forced | input | 1 | 1 = clear-to-send pin unused, treated as asserted |
| fifo_empty | input | 1 | Transmit queue holds no entry |
| fifo_data | input | DATA_W | Payload byte at the queue head |
| fifo_eof | input | 1 | Head byte is the last of its frame |
| fifo_rd | output | 1 | One-period pulse: head entry consumed |
| rts | output | 1 | Request-to-send, active high |
| txd | output | 1 | Serial data, idles at 1 |

## Verification
The bench uses the default parameters: DATA_W = 8 and a 0x7E flag. With these values a frame of up to four bytes stays short enough to compare every bit period of `rts` and `txd` against a timeline computed in the bench. The sweep covers frame lengths 1 to 4, clear-to-send grant delays of 0 to 3 periods, and both settings of `cts_forced`. Back-to-back queued frames and an abort during the opening flag exercise the one-period gap and the restart path.

// File: rtl/tx_hs_pkg.sv
package tx_hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_OPEN  = 3'd2,
    ST_DATA  = 3'd3,
    ST_CLOSE = 3'd4,
    ST_TAIL  = 3'd5
  } hs_state_t;
endpackage

// File: rtl/tx_hs_rst_sync.sv
module tx_hs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/tx_hs_byte_reg.sv
module tx_hs_byte_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_eof,
  output logic [DATA_W-1:0] byte_q,
  output logic              last_q,
  output logic              fifo_rd
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      byte_q <= fifo_data;
      last_q <= fifo_eof;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fifo_rd <= 1'b0;
    else        fifo_rd <= load;
  end
endmodule

// File: rtl/tx_hs_ctrl.sv
module tx_hs_ctrl
  import tx_hs_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter logic [DATA_W-1:0] FLAG_PAT = 8'h7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              cts_ok,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic [DATA_W-1:0] byte_q,
  input  logic              last_q,
  output logic              load,
  output logic              rts,
  output logic              txd
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] BIT_MAX = CNT_W'(DATA_W - 1);

  hs_state_t        st_q, st_n;
  logic [CNT_W-1:0] bc_q, bc_n;
  logic             rts_n, txd_n, bit_last;

  assign bit_last = (bc_q == BIT_MAX);

  // next-state logic
  always_comb begin
    st_n = st_q;
    bc_n = bc_q;
    load = 1'b0;
    if (!tx_en) begin
      st_n = ST_IDLE;
      bc_n = '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          bc_n = '0;
          if (!fifo_empty) st_n = cts_ok ? ST_OPEN : ST_WAIT;
        end
        ST_WAIT: begin
          bc_n = '0;
          if (cts_ok) st_n = ST_OPEN;
        end
        ST_OPEN: begin
          if (bit_last) begin
            bc_n = '0;
            if (fifo_empty) st_n = ST_CLOSE;
            else begin
              st_n = ST_DATA;
              load = 1'b1;
            end
          end else bc_n = bc_q + CNT_W'(1);
        end
        ST_DATA: begin
          if (bit_last) begin
            bc_n = '0;
            if (last_q || fifo_empty) st_n = ST_CLOSE;
            else load = 1'b1;
          end else bc_n = bc_q + CNT_W'(1);
        end
        ST_CLOSE: begin
          if (bit_last) begin
            bc_n = '0;
            st_n = ST_TAIL;
          end else bc_n = bc_q + CNT_W'(1);
        end
        ST_TAIL: begin
          bc_n = '0;
          st_n = ST_IDLE;
        end
        default: begin
          bc_n = '0;
          st_n = ST_IDLE;
        end
      endcase
    end
  end

  // output selection follows the state being entered
  always_comb begin
    rts_n = (st_n != ST_IDLE);
    case (st_n)
      ST_OPEN, ST_CLOSE: txd_n = FLAG_PAT[bc_n];
      ST_DATA:           txd_n = load ? fifo_data[bc_n] : byte_q[bc_n];
      default:           txd_n = 1'b1;
    endcase
  end

  // registers
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      bc_q <= '0;
      rts  <= 1'b0;
      txd  <= 1'b1;
    end else begin
      st_q <= st_n;
      bc_q <= bc_n;
      rts  <= rts_n;
      txd  <= txd_n;
    end
  end
endmodule

// File: rtl/tx_handshake_seq.sv
module tx_handshake_seq #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] FLAG_PAT = 8'h7E
) (
  input  logic              tclk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              cts,
  input  logic              cts_forced,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_eof,
  output logic              fifo_rd,
  output logic              rts,
  output logic              txd
);
  logic              rst_n_sync;
  logic              cts_ok;
  logic              load;
  logic [DATA_W-1:0] byte_q;
  logic              last_q;

  assign cts_ok = cts | cts_forced;

  tx_hs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (tclk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  tx_hs_byte_reg #(.DATA_W(DATA_W)) u_byte (
    .clk       (tclk),
    .rst_n     (rst_n_sync),
    .load      (load),
    .fifo_data (fifo_data),
    .fifo_eof  (fifo_eof),
    .byte_q    (byte_q),
    .last_q    (last_q),
    .fifo_rd   (fifo_rd)
  );

  tx_hs_ctrl #(.DATA_W(DATA_W), .FLAG_PAT(FLAG_PAT)) u_ctrl (
    .clk        (tclk),
    .rst_n      (rst_n_sync),
    .tx_en      (tx_en),
    .cts_ok     (cts_ok),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .byte_q     (byte_q),
    .last_q     (last_q),
    .load       (load),
    .rts        (rts),
    .txd        (txd)
  );
endmodule

// File: rtl/tx_hs_checker.sv
module tx_hs_checker #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] FLAG_PAT = 8'h7E
) (
  input logic tclk,
  input logic rst_n,
  input logic tx_en,
  input logic cts,
  input logic cts_forced,
  input logic fifo_empty,
  input logic fifo_rd,
  input logic rts,
  input logic txd
);
  logic [1:0] arm_cnt;
  logic       armed;

  always_ff @(negedge tclk or negedge rst_n) begin
    if (!rst_n)          arm_cnt <= '0;
    else if (!armed)     arm_cnt <= arm_cnt + 2'd1;
  end
  assign armed = (arm_cnt == 2'd3);

  assert_idle_high_R11: assert property (@(negedge tclk) disable iff (!rst_n)
    !rts |-> txd);

  assert_rts_needs_data_R2: assert property (@(negedge tclk) disable iff (!rst_n)
    (armed && rts && !$past(rts)) |-> $past(tx_en && !fifo_empty));

  assert_zero_delay_R3: assert property (@(negedge tclk) disable iff (!rst_n)
    (armed && !rts && tx_en && !fifo_empty && (cts || cts_forced))
      |=> (rts && txd == FLAG_PAT[0]));

  assert_abort_R9: assert property (@(negedge tclk) disable iff (!rst_n)
    (armed && !tx_en) |=> (!rts && txd));

  assert_pop_in_frame_R10: assert property (@(negedge tclk) disable iff (!rst_n)
    fifo_rd |-> rts);
endmodule

bind tx_handshake_seq tx_hs_checker #(.DATA_W(DATA_W), .FLAG_PAT(FLAG_PAT)) u_chk (
  .tclk       (tclk),
  .rst_n      (rst_n),
  .tx_en      (tx_en),
  .cts        (cts),
  .cts_forced (cts_forced),
  .fifo_empty (fifo_empty),
  .fifo_rd    (fifo_rd),
  .rts        (rts),
  .txd        (txd)
);

// File: tb/test_tx_handshake_seq.sv
module test_tx_handshake_seq;
  localparam logic [7:0] FLAG = 8'h7E;

  logic       tclk = 1'b0;
  logic       rst_n, tx_en, cts, cts_forced;
  logic       fifo_empty, fifo_eof, fifo_rd, rts, txd;
  logic [7:0] fifo_data;

  logic [8:0] q[$];
  int n_chk = 0, n_fail = 0, pop_cnt = 0, fno = 0;

  always #2 tclk = ~tclk;

  tx_handshake_seq i_tx_handshake_seq (
    .tclk(tclk), .rst_n(rst_n), .tx_en(tx_en), .cts(cts), .cts_forced(cts_forced),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_eof(fifo_eof),
    .fifo_rd(fifo_rd), .rts(rts), .txd(txd));

  task automatic refresh();
    fifo_empty = (q.size() == 0);
    fifo_data  = (q.size() != 0) ? q[0][7:0] : 8'h00;
    fifo_eof   = (q.size() != 0) ? q[0][8] : 1'b0;
  endtask

  // queue model: pops on the rising edge, away from the design's edge
  always @(posedge tclk) begin
    if (fifo_rd && q.size() != 0) begin
      void'(q.pop_front());
      pop_cnt++;
      refresh();
    end
  end

  function automatic logic [7:0] dbyte(int f, int i);
    return 8'((f * 37 + i * 91 + 13) ^ (i << 3));
  endfunction

  function automatic logic exp_bit(int f, int n, int d, int j);
    int k;
    logic [7:0] b;
    if (j < d) return 1'b1;
    k = j - d;
    if (k < 8) return FLAG[k];
    k = k - 8;
    if (k < 8 * n) begin
      b = dbyte(f, k / 8);
      return b[k % 8];
    end
    k = k - 8 * n;
    if (k < 8) return FLAG[k];
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_frame(int f, int n);
    for (int i = 0; i < n; i++) q.push_back({(i == n - 1), dbyte(f, i)});
    refresh();
  endtask

  // The next rising-edge sample is the first with rts high.
  task automatic watch_frame(int f, int n, int d, bit raise, bit forced, string first_tag);
    int total = d + 17 + 8 * n;
    int p0 = pop_cnt;
    logic e;
    string tag;
    for (int j = 0; j < total; j++) begin
      @(posedge tclk);
      e = exp_bit(f, n, d, j);
      if (j == 0) tag = first_tag;
      else if (j < d) tag = "R4 hold";
      else if (j == d && d > 0) tag = "R4 start";
      else if (j == d && forced) tag = "R5 start";
      else if (j == d) tag = "R3 start";
      else if (j == total - 1) tag = "R7 tail";
      else tag = "R6 bit";
      chk(rts === 1'b1, {tag, " rts"}, int'(rts), 1);
      chk(txd === e, {tag, " txd"}, int'(txd), int'(e));
      if (raise && j == d - 1) cts = 1'b1;
    end
    @(posedge tclk);
    chk(rts === 1'b0, "R7 rts falls", int'(rts), 0);
    chk(txd === 1'b1, "R11 idle txd", int'(txd), 1);
    chk(pop_cnt - p0 == n, "R10 pops", pop_cnt - p0, n);
  endtask

  initial begin
    repeat (200000) @(posedge tclk);
    n_fail++; n_chk++;
    $display("FAIL R0 watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_en = 1'b0; cts = 1'b0; cts_forced = 1'b0;
    refresh();
    repeat (3) @(posedge tclk);
    chk(rts === 1'b0, "R1 rts", int'(rts), 0);
    chk(txd === 1'b1, "R1 txd", int'(txd), 1);
    chk(fifo_rd === 1'b0, "R1 fifo_rd", int'(fifo_rd), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge tclk);
    tx_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge tclk);
      chk(rts === 1'b0, "R2 empty queue", int'(rts), 0);
      chk(txd === 1'b1, "R11 empty queue", int'(txd), 1);
    end

    // sweep: forced setting x grant delay x frame length
    for (int fr = 0; fr < 2; fr++)
      for (int d = 0; d < 4; d++)
        for (int n = 1; n < 5; n++) begin
          fno++;
          cts_forced = fr[0];
          cts = (fr == 0 && d == 0);
          @(posedge tclk);
          push_frame(fno, n);
          watch_frame(fno, n, (fr != 0) ? 0 : d, (fr == 0 && d > 0), fr[0], "R2 rise");
          cts = 1'b0;
          repeat (2) @(posedge tclk);
        end
    cts_forced = 1'b0;

    // back-to-back frames: one period gap
    cts = 1'b1;
    @(posedge tclk);
    push_frame(fno + 1, 2);
    push_frame(fno + 2, 1);
    watch_frame(fno + 1, 2, 0, 1'b0, 1'b0, "R2 rise");
    watch_frame(fno + 2, 1, 0, 1'b0, 1'b0, "R8 re-rise");
    fno += 2;
    repeat (2) @(posedge tclk);

    // abort during opening flag, then restart
    @(posedge tclk);
    push_frame(fno + 1, 3);
    for (int j = 0; j < 5; j++) @(posedge tclk);
    chk(rts === 1'b1, "R9 pre-abort rts", int'(rts), 1);
    tx_en = 1'b0;
    @(posedge tclk);
    chk(rts === 1'b0, "R9 abort rts", int'(rts), 0);
    chk(txd === 1'b1, "R9 abort txd", int'(txd), 1);
    for (int j = 0; j < 3; j++) begin
      @(posedge tclk);
      chk(rts === 1'b0, "R2 disabled", int'(rts), 0);
    end
    q.delete();
    push_frame(fno + 2, 1);
    tx_en = 1'b1;
    watch_frame(fno + 2, 1, 0, 1'b0, 1'b0, "R9 restart");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule